// File: doc/BRIEF.md
# Event-Seeded Shift-Register Random Bit Source

This block produces a stream of pseudo-random bits from a 64-bit shift register with XOR feedback. The starting state comes from the timing of asynchronous external events, such as an operator pressing a button. A free-running counter runs at the core clock rate. Each event is synchronised and edge-detected, and the low bits of the counter at that moment are shifted into a seed accumulator. A single event yields little entropy, so several events are gathered before a seed is used.

When software or a controlling state machine pulses the load strobe, the accumulated seed is copied into the shift register. From then on the register advances once on each clock edge where enable is high. Only the top register bit is offered as the random output, because neighbouring register bits are strongly correlated. The full state is exposed for debug.

Top module: `entropy_lfsr_gen`

## Requirements
- R1: After reset the shift register holds the value 1, `seeded_o` is 0 and `rand_bit_o` is 0.
- R2: On an enabled step, the register shifts one place toward bit 63 and drops the old bit 63. The new bit 0 is the XOR of the old bits 63 and 62.
- R3: `rand_bit_o` always equals bit 63 of the register, so each step yields exactly one new output bit.
- R4: With `enable_i` low and no load, the register keeps its value.
- R5: A load strobe copies the accumulated seed into the register on the same clock edge. Load takes priority over a step in that cycle. `seeded_o` goes high after the first load and stays high until reset.
- R6: If the accumulated seed is all zeros when a load strobe arrives, the value 1 is loaded instead.
- R7: `event_i` passes through a two-flop synchroniser and a rising-edge detector. Each rising edge causes exactly one capture, no matter how long the input stays high.
- R8: The counter starts at 0 at reset release and counts every clock. Suppose `event_i` rises between clock edge k and edge k+1, counting edges from reset release. The captured value is then (k+2) mod 16, that is, the 4 low counter bits.
- R9: Each capture shifts the 4 bits into seed bits 3:0 and moves the older contents up by 4. After 16 events the seed is full, and each further event pushes the oldest 4 bits out.
- R10: The shift register is never all zeros.
- R11: Two runs from reset with identical event timing produce identical output bit sequences.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Core clock, also the counter clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| event_i | input | 1 | Asynchronous entropy event (e.g. button) |
| seed_load_i | input | 1 | Single-cycle strobe: load seed into register |
| enable_i | input | 1 | Advance the register one step this cycle |
| rand_bit_o | output | 1 | Serial random bit (register bit 63) |
| seeded_o | output | 1 | High once a seed has been loaded |
| state_o | output | 64 | Full register state for debug |

## Verification
The bench uses the default parameters: a 64-bit register, a 4-bit capture and a 16-bit counter. With these values, sixteen events fill the seed, and an eighteenth event already shows the oldest nibbles being pushed out. Event times vary, so the counter capture phase is exercised on different values. The seed is checked through a load, and runs of more than 64 steps reach every feedback position. A zero-seed load, a load issued together with enable, and a repeat of the identical event schedule after a fresh reset cover the lock-up guard, the load priority and determinism.

// File: rtl/erng_pkg.sv
package erng_pkg;
  localparam int unsigned DEF_STATE_W = 64;
  localparam int unsigned DEF_CAP_W   = 4;
  localparam int unsigned DEF_CNT_W   = 16;
  localparam int unsigned SYNC_N      = 2;
endpackage

// File: rtl/erng_evt_sync.sv
module erng_evt_sync #(
  parameter int unsigned STAGES = erng_pkg::SYNC_N
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic evt_i,
  output logic rise_o
);
  logic [STAGES-1:0] sync_q;
  logic              prev_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sync_q <= '0;
      prev_q <= 1'b0;
    end else begin
      sync_q <= {sync_q[STAGES-2:0], evt_i};
      prev_q <= sync_q[STAGES-1];
    end
  end

  assign rise_o = sync_q[STAGES-1] & ~prev_q;

  // one pulse per edge
  p_single_pulse_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rise_o |=> !rise_o);
endmodule

// File: rtl/erng_harvest.sv
module erng_harvest #(
  parameter int unsigned STATE_W = erng_pkg::DEF_STATE_W,
  parameter int unsigned CAP_W   = erng_pkg::DEF_CAP_W,
  parameter int unsigned CNT_W   = erng_pkg::DEF_CNT_W
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               rise_i,
  output logic [STATE_W-1:0] seed_o
);
  localparam int unsigned KEEP_W = STATE_W - CAP_W;

  logic [CNT_W-1:0]   cnt_q;
  logic [STATE_W-1:0] acc_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) cnt_q <= '0;
    else         cnt_q <= cnt_q + 1'b1;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     acc_q <= '0;
    else if (rise_i) acc_q <= {acc_q[KEEP_W-1:0], cnt_q[CAP_W-1:0]};
  end

  assign seed_o = acc_q;

  p_capture_low_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rise_i |=> acc_q[CAP_W-1:0] == $past(cnt_q[CAP_W-1:0]));
  p_shift_up_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rise_i |=> acc_q[STATE_W-1:CAP_W] == $past(acc_q[KEEP_W-1:0]));
  p_idle_hold_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !rise_i |=> $stable(acc_q));
endmodule

// File: rtl/erng_lfsr.sv
module erng_lfsr #(
  parameter int unsigned STATE_W = erng_pkg::DEF_STATE_W
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               load_i,
  input  logic               en_i,
  input  logic [STATE_W-1:0] seed_i,
  output logic [STATE_W-1:0] state_o,
  output logic               seeded_o
);
  localparam int unsigned TAP_HI = STATE_W - 1;
  localparam int unsigned TAP_LO = STATE_W - 2;
  localparam logic [STATE_W-1:0] ONE = STATE_W'(1);

  logic [STATE_W-1:0] state_q;
  logic               seeded_q;
  logic [STATE_W-1:0] load_val;

  // all-zero is the lock-up state
  assign load_val = (seed_i == '0) ? ONE : seed_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q  <= ONE;
      seeded_q <= 1'b0;
    end else if (load_i) begin
      state_q  <= load_val;
      seeded_q <= 1'b1;
    end else if (en_i) begin
      state_q  <= {state_q[TAP_LO:0], state_q[TAP_HI] ^ state_q[TAP_LO]};
    end
  end

  assign state_o  = state_q;
  assign seeded_o = seeded_q;

  p_never_zero_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    state_q != '0);
  p_hold_idle_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!load_i && !en_i) |=> $stable(state_q));
  p_zero_seed_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (load_i && seed_i == '0) |=> state_q == ONE);
  p_seeded_sticky_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    seeded_q |=> seeded_q);
  p_load_wins_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (load_i && seed_i != '0) |=> state_q == $past(seed_i));
endmodule

// File: rtl/entropy_lfsr_gen.sv
module entropy_lfsr_gen #(
  parameter int unsigned STATE_W = erng_pkg::DEF_STATE_W,
  parameter int unsigned CAP_W   = erng_pkg::DEF_CAP_W,
  parameter int unsigned CNT_W   = erng_pkg::DEF_CNT_W
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               event_i,
  input  logic               seed_load_i,
  input  logic               enable_i,
  output logic               rand_bit_o,
  output logic               seeded_o,
  output logic [STATE_W-1:0] state_o
);
  logic               rise;
  logic [STATE_W-1:0] seed;
  logic [STATE_W-1:0] state;

  erng_evt_sync #(.STAGES(erng_pkg::SYNC_N)) u_sync (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .evt_i (event_i),
    .rise_o(rise)
  );

  erng_harvest #(.STATE_W(STATE_W), .CAP_W(CAP_W), .CNT_W(CNT_W)) u_harvest (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .rise_i(rise),
    .seed_o(seed)
  );

  erng_lfsr #(.STATE_W(STATE_W)) u_lfsr (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .load_i  (seed_load_i),
    .en_i    (enable_i),
    .seed_i  (seed),
    .state_o (state),
    .seeded_o(seeded_o)
  );

  assign state_o    = state;
  assign rand_bit_o = state[STATE_W-1];

  p_out_is_msb_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rand_bit_o == state_o[STATE_W-1]);
endmodule

// File: tb/entropy_lfsr_gen_tb_top.sv
`timescale 1ns/1ps
module entropy_lfsr_gen_tb_top;
  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic        event_i = 1'b0;
  logic        seed_load_i = 1'b0;
  logic        enable_i = 1'b0;
  logic        rand_bit_o;
  logic        seeded_o;
  logic [63:0] state_o;

  int checks = 0;
  int errors = 0;
  int ncyc;
  logic [63:0] acc_m;
  logic [63:0] st_m;
  logic [63:0] exp_q[$];
  logic        log1[$];
  logic        log2[$];
  int          log_sel = 0;
  logic [63:0] mon_e;

  always #5 clk = ~clk;

  entropy_lfsr_gen dut_i (
    .clk_i(clk), .rst_ni(rst_ni), .event_i(event_i),
    .seed_load_i(seed_load_i), .enable_i(enable_i),
    .rand_bit_o(rand_bit_o), .seeded_o(seeded_o), .state_o(state_o)
  );

  // bench time base: clock edges since reset release
  always @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) ncyc <= 0;
    else         ncyc <= ncyc + 1;
  end

  function automatic logic [63:0] nxt(input logic [63:0] s);
    return {s[62:0], s[63] ^ s[62]};
  endfunction

  task automatic chk(input bit ok, input string req, input logic [63:0] act,
                     input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  // monitor: scoreboard compare after each edge
  always @(posedge clk) begin
    #3;
    if (exp_q.size() > 0) begin
      mon_e = exp_q.pop_front();
      chk(state_o == mon_e, "R2/R5 state", state_o, mon_e);
      chk(rand_bit_o == mon_e[63], "R3 serial bit", 64'(rand_bit_o), 64'(mon_e[63]));
      chk(state_o != 64'd0, "R10 nonzero", state_o, 64'd1);
      if (log_sel == 1) log1.push_back(rand_bit_o);
      if (log_sel == 2) log2.push_back(rand_bit_o);
    end
  end

  task automatic do_reset();
    @(negedge clk);
    rst_ni = 1'b0; event_i = 1'b0; seed_load_i = 1'b0; enable_i = 1'b0;
    repeat (3) @(negedge clk);
    rst_ni = 1'b1;
    acc_m = '0;
    st_m  = 64'd1;
  endtask

  task automatic step(input int n, input bit en);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      enable_i = en;
      if (en) st_m = nxt(st_m);
      exp_q.push_back(st_m);
    end
    @(negedge clk);
    enable_i = 1'b0;
  endtask

  task automatic pulse_event(input int gap);
    int k;
    repeat (gap) @(negedge clk);
    event_i = 1'b1;
    k = ncyc;
    acc_m = {acc_m[59:0], 4'(k + 2)}; // R8 capture value, R9 shift
    repeat (4) @(negedge clk);       // held high: still one capture (R7)
    event_i = 1'b0;
    repeat (4) @(negedge clk);
  endtask

  task automatic load_seed();
    @(negedge clk);
    seed_load_i = 1'b1;
    enable_i    = 1'b1;              // R5 load beats step
    st_m = (acc_m == 64'd0) ? 64'd1 : acc_m;
    exp_q.push_back(st_m);
    @(negedge clk);
    seed_load_i = 1'b0;
    enable_i    = 1'b0;
    chk(seeded_o == 1'b1, "R5 seeded", 64'(seeded_o), 64'd1);
  endtask

  task automatic run_schedule(input int sel);
    do_reset();
    log_sel = sel;
    for (int i = 0; i < 18; i++) pulse_event((i * 5) % 7 + 1);
    load_seed();
    step(120, 1'b1);
    @(negedge clk);
    log_sel = 0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    do_reset();
    @(negedge clk);
    chk(state_o == 64'd1, "R1 reset state", state_o, 64'd1);
    chk(seeded_o == 1'b0, "R1 seeded low", 64'(seeded_o), 64'd0);
    chk(rand_bit_o == 1'b0, "R1 bit low", 64'(rand_bit_o), 64'd0);

    step(70, 1'b1);                  // R2 R3 from default state
    step(5, 1'b0);                   // R4 hold
    chk(seeded_o == 1'b0, "R5 not yet seeded", 64'(seeded_o), 64'd0);

    load_seed();                     // no events: R6 zero seed gives 1
    @(negedge clk);
    chk(state_o == 64'd1, "R6 zero seed", state_o, 64'd1);
    step(3, 1'b0);
    chk(seeded_o == 1'b1, "R5 sticky", 64'(seeded_o), 64'd1);

    run_schedule(1);                 // R7 R8 R9 via load compare
    run_schedule(2);
    chk(log1.size() == log2.size() && log1.size() > 0, "R11 log length",
        64'(log2.size()), 64'(log1.size()));
    for (int i = 0; i < log1.size() && i < log2.size(); i++)
      chk(log1[i] == log2[i], "R11 repeatability", 64'(log2[i]), 64'(log1[i]));

    repeat (2) @(negedge clk);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule